// File: doc/BRIEF.md
# Paired-Page Translation Buffer

This block is a fully associative translation buffer. It turns a 32-bit virtual address into a physical address and a pair of permission bits, for either a load or a store. A tag covers two neighbouring 4 KB pages. Virtual address bit 12 picks the lower ("even") or upper ("odd") half, and each half has its own frame number, valid flag and dirty flag. Each entry also holds an 8-bit address-space identifier and a global flag. When the global flag is set, the identifier check is skipped.

A lookup is a one-cycle request pulse carrying the address, the store flag and the current identifier. The registered answer comes back on the next cycle as a two-bit outcome code, a physical address and the permission bits. Entries are loaded through a separate write port that is addressed by slot number. Walking the page tables, choosing a victim slot and raising exceptions are left to the logic around the block.

Top module: `ptlb_xlate`

## Requirements
- R1: The buffer has 16 slots, all compared in parallel. A slot loaded through the write port (`ew_en` high, slot number on `ew_idx`) is seen by every lookup requested in a later cycle.
- R2: A slot qualifies only if it is global or its stored identifier equals `cur_asid`. A global slot matches under any identifier.
- R3: A slot qualifies only if its 19-bit tag equals virtual address bits 31:13. A difference in any one of these bits, bit 13 included, makes the slot miss.
- R4: Virtual address bit 12 selects the half of the hit slot: 0 selects the even-page fields and 1 selects the odd-page fields.
- R5: If the selected half's valid flag is clear, the outcome is 2'b01 (invalid) for both loads and stores.
- R6: A store (`lk_wr`=1) to a valid half whose dirty flag is clear gives outcome 2'b10 (dirty fault), with `rs_pa`=0 and both permission bits 0.
- R7: On success the outcome is 2'b00, `rs_pa` is the selected frame number in bits 31:12 with virtual bits 11:0 below it, `rs_rd_ok`=1, and `rs_wr_ok` equals the selected dirty flag.
- R8: If no slot qualifies, the outcome is 2'b11 (no match), with `rs_pa`=0 and both permission bits 0. The same zero outputs go with outcome 2'b01.
- R9: `rs_vld` is high exactly in the cycle after a cycle with `lk_req` high. Back-to-back requests give back-to-back results, and the result outputs hold their values while no request is made.
- R10: When several slots qualify, the lowest-numbered one supplies the translation.
- R11: Reset clears every slot to tag 0, identifier 0, not global, both halves invalid and clean, and clears `rs_vld`. After reset, a lookup of tag 0 under identifier 0 gives 2'b01 and any other lookup gives 2'b11.
- R12: A lookup made in the same cycle as a slot write sees the slot contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| lk_req | input | 1 | Lookup request strobe |
| lk_va | input | 32 | Virtual address to translate |
| lk_wr | input | 1 | 1 = store access, 0 = load access |
| cur_asid | input | 8 | Current address-space identifier |
| ew_en | input | 1 | Slot write strobe |
| ew_idx | input | 4 | Slot number to write |
| ew_tag | input | 19 | Tag (virtual bits 31:13) |
| ew_asid | input | 8 | Identifier stored in the slot |
| ew_glob | input | 1 | Global flag |
| ew_pfn_even | input | 20 | Frame number for the even page |
| ew_val_even | input | 1 | Valid flag for the even page |
| ew_drt_even | input | 1 | Dirty flag for the even page |
| ew_pfn_odd | input | 20 | Frame number for the odd page |
| ew_val_odd | input | 1 | Valid flag for the odd page |
| ew_drt_odd | input | 1 | Dirty flag for the odd page |
| rs_vld | output | 1 | Result strobe, one cycle after a request |
| rs_code | output | 2 | Outcome: 00 hit, 01 invalid, 10 dirty fault, 11 no match |
| rs_pa | output | 32 | Physical address (0 unless the outcome is 00) |
| rs_rd_ok | output | 1 | Load permitted |
| rs_wr_ok | output | 1 | Store permitted |

## Verification
A slot write and a lookup can land in the same cycle, and they may target the very slot being written. The bench provokes this by raising `ew_en` and `lk_req` on the same edge, with the write installing the tag the lookup asks for. The expected answer is taken from the bench's table model before that model takes the write, so the lookup must report no match. A second lookup one cycle later must return the new translation. The bench also checks lowest-slot priority while two slots hold the same tag.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;

  typedef enum logic [1:0] {
    RES_HIT   = 2'b00,
    RES_INVAL = 2'b01,
    RES_DIRTY = 2'b10,
    RES_MISS  = 2'b11
  } res_e;

endpackage

// File: rtl/ptlb_store.sv
// Slot storage: one register set per slot, loaded by slot number.
module ptlb_store #(
  parameter int N_ENT  = 16,
  parameter int TAG_W  = 19,
  parameter int ASID_W = 8,
  parameter int PFN_W  = 20,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_glob,
  input  logic [PFN_W-1:0]  wr_pfn0,
  input  logic              wr_v0,
  input  logic              wr_d0,
  input  logic [PFN_W-1:0]  wr_pfn1,
  input  logic              wr_v1,
  input  logic              wr_d1,
  output logic [TAG_W-1:0]  st_tag  [N_ENT],
  output logic [ASID_W-1:0] st_asid [N_ENT],
  output logic              st_glob [N_ENT],
  output logic [PFN_W-1:0]  st_pfn0 [N_ENT],
  output logic              st_v0   [N_ENT],
  output logic              st_d0   [N_ENT],
  output logic [PFN_W-1:0]  st_pfn1 [N_ENT],
  output logic              st_v1   [N_ENT],
  output logic              st_d1   [N_ENT]
);

  for (genvar g = 0; g < N_ENT; g++) begin : g_slot
    logic sel_we;
    assign sel_we = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_tag[g]  <= '0;
        st_asid[g] <= '0;
        st_glob[g] <= 1'b0;
        st_pfn0[g] <= '0;
        st_v0[g]   <= 1'b0;
        st_d0[g]   <= 1'b0;
        st_pfn1[g] <= '0;
        st_v1[g]   <= 1'b0;
        st_d1[g]   <= 1'b0;
      end else if (sel_we) begin
        st_tag[g]  <= wr_tag;
        st_asid[g] <= wr_asid;
        st_glob[g] <= wr_glob;
        st_pfn0[g] <= wr_pfn0;
        st_v0[g]   <= wr_v0;
        st_d0[g]   <= wr_d0;
        st_pfn1[g] <= wr_pfn1;
        st_v1[g]   <= wr_v1;
        st_d1[g]   <= wr_d1;
      end
    end
  end

endmodule

// File: rtl/ptlb_match.sv
// Parallel compare of all slots and lowest-index priority pick.
module ptlb_match #(
  parameter int N_ENT  = 16,
  parameter int TAG_W  = 19,
  parameter int ASID_W = 8,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic [TAG_W-1:0]  q_tag,
  input  logic [ASID_W-1:0] q_asid,
  input  logic [TAG_W-1:0]  st_tag  [N_ENT],
  input  logic [ASID_W-1:0] st_asid [N_ENT],
  input  logic              st_glob [N_ENT],
  output logic              any_hit,
  output logic [IDX_W-1:0]  hit_idx
);

  logic [N_ENT-1:0] hit_vec;

  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    assign hit_vec[g] = (st_glob[g] || (st_asid[g] == q_asid)) &&
                        (st_tag[g] == q_tag);
  end

  always_comb begin
    hit_idx = '0;
    for (int k = N_ENT - 1; k >= 0; k--) begin
      if (hit_vec[k]) hit_idx = IDX_W'(k);
    end
  end

  assign any_hit = |hit_vec;

endmodule

// File: rtl/ptlb_xlate.sv
// Top: slot storage, compare, half select, registered result.
module ptlb_xlate #(
  parameter int N_ENT   = 16,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int PG_BITS = 12,
  parameter int ASID_W  = 8,
  localparam int IDX_W  = $clog2(N_ENT),
  localparam int TAG_W  = VA_W - PG_BITS - 1,
  localparam int PFN_W  = PA_W - PG_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_req,
  input  logic [VA_W-1:0]   lk_va,
  input  logic              lk_wr,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic              ew_en,
  input  logic [IDX_W-1:0]  ew_idx,
  input  logic [TAG_W-1:0]  ew_tag,
  input  logic [ASID_W-1:0] ew_asid,
  input  logic              ew_glob,
  input  logic [PFN_W-1:0]  ew_pfn_even,
  input  logic              ew_val_even,
  input  logic              ew_drt_even,
  input  logic [PFN_W-1:0]  ew_pfn_odd,
  input  logic              ew_val_odd,
  input  logic              ew_drt_odd,
  output logic              rs_vld,
  output logic [1:0]        rs_code,
  output logic [PA_W-1:0]   rs_pa,
  output logic              rs_rd_ok,
  output logic              rs_wr_ok
);
  import ptlb_pkg::*;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [TAG_W-1:0]  st_tag  [N_ENT];
  logic [ASID_W-1:0] st_asid [N_ENT];
  logic              st_glob [N_ENT];
  logic [PFN_W-1:0]  st_pfn0 [N_ENT];
  logic              st_v0   [N_ENT];
  logic              st_d0   [N_ENT];
  logic [PFN_W-1:0]  st_pfn1 [N_ENT];
  logic              st_v1   [N_ENT];
  logic              st_d1   [N_ENT];

  ptlb_store #(
    .N_ENT(N_ENT), .TAG_W(TAG_W), .ASID_W(ASID_W), .PFN_W(PFN_W)
  ) u_store (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wr_en  (ew_en),
    .wr_idx (ew_idx),
    .wr_tag (ew_tag),
    .wr_asid(ew_asid),
    .wr_glob(ew_glob),
    .wr_pfn0(ew_pfn_even),
    .wr_v0  (ew_val_even),
    .wr_d0  (ew_drt_even),
    .wr_pfn1(ew_pfn_odd),
    .wr_v1  (ew_val_odd),
    .wr_d1  (ew_drt_odd),
    .st_tag (st_tag),
    .st_asid(st_asid),
    .st_glob(st_glob),
    .st_pfn0(st_pfn0),
    .st_v0  (st_v0),
    .st_d0  (st_d0),
    .st_pfn1(st_pfn1),
    .st_v1  (st_v1),
    .st_d1  (st_d1)
  );

  logic             any_hit;
  logic [IDX_W-1:0] hit_idx;

  ptlb_match #(
    .N_ENT(N_ENT), .TAG_W(TAG_W), .ASID_W(ASID_W)
  ) u_match (
    .q_tag  (lk_va[VA_W-1:PG_BITS+1]),
    .q_asid (cur_asid),
    .st_tag (st_tag),
    .st_asid(st_asid),
    .st_glob(st_glob),
    .any_hit(any_hit),
    .hit_idx(hit_idx)
  );

  // half select and outcome
  logic             odd_half;
  logic [PFN_W-1:0] sel_pfn;
  logic             sel_v;
  logic             sel_d;

  assign odd_half = lk_va[PG_BITS];
  assign sel_pfn  = odd_half ? st_pfn1[hit_idx] : st_pfn0[hit_idx];
  assign sel_v    = odd_half ? st_v1[hit_idx]   : st_v0[hit_idx];
  assign sel_d    = odd_half ? st_d1[hit_idx]   : st_d0[hit_idx];

  res_e            nx_code;
  logic [PA_W-1:0] nx_pa;
  logic            nx_rd;
  logic            nx_wr;

  always_comb begin
    nx_code = RES_MISS;
    nx_pa   = '0;
    nx_rd   = 1'b0;
    nx_wr   = 1'b0;
    if (any_hit) begin
      if (!sel_v) begin
        nx_code = RES_INVAL;
      end else if (lk_wr && !sel_d) begin
        nx_code = RES_DIRTY;
      end else begin
        nx_code = RES_HIT;
        nx_pa   = {sel_pfn, lk_va[PG_BITS-1:0]};
        nx_rd   = 1'b1;
        nx_wr   = sel_d;
      end
    end
  end

  // result register, loaded only on a request
  res_e code_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) rs_vld <= 1'b0;
    else            rs_vld <= lk_req;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      code_q   <= RES_MISS;
      rs_pa    <= '0;
      rs_rd_ok <= 1'b0;
      rs_wr_ok <= 1'b0;
    end else if (lk_req) begin
      code_q   <= nx_code;
      rs_pa    <= nx_pa;
      rs_rd_ok <= nx_rd;
      rs_wr_ok <= nx_wr;
    end
  end

  assign rs_code = code_q;

endmodule

// File: rtl/ptlb_checker.sv
module ptlb_checker #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int PG_BITS = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            lk_req,
  input logic [VA_W-1:0] lk_va,
  input logic            lk_wr,
  input logic            rs_vld,
  input logic [1:0]      rs_code,
  input logic [PA_W-1:0] rs_pa,
  input logic            rs_rd_ok,
  input logic            rs_wr_ok
);

  assert_req_gives_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> rs_vld);

  assert_no_spurious_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !rs_vld);

  assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> ($stable(rs_code) && $stable(rs_pa) && $stable(rs_wr_ok)));

  assert_store_implies_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rs_wr_ok |-> rs_rd_ok);

  assert_fault_no_xlate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_vld && rs_code != 2'b00) |-> (!rs_rd_ok && !rs_wr_ok && rs_pa == '0));

  assert_dirty_only_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req && !lk_wr |=> rs_code != 2'b10);

  assert_offset_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_vld && rs_code == 2'b00) |-> rs_pa[PG_BITS-1:0] == $past(lk_va[PG_BITS-1:0]));

endmodule

bind ptlb_xlate ptlb_checker #(
  .VA_W(VA_W), .PA_W(PA_W), .PG_BITS(PG_BITS)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_int_n),
  .lk_req  (lk_req),
  .lk_va   (lk_va),
  .lk_wr   (lk_wr),
  .rs_vld  (rs_vld),
  .rs_code (rs_code),
  .rs_pa   (rs_pa),
  .rs_rd_ok(rs_rd_ok),
  .rs_wr_ok(rs_wr_ok)
);

// File: tb/ptlb_xlate_test.sv
`timescale 1ns/1ps
module ptlb_xlate_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_req, lk_wr, ew_en, ew_glob;
  logic [31:0] lk_va;
  logic [7:0]  cur_asid, ew_asid;
  logic [3:0]  ew_idx;
  logic [18:0] ew_tag;
  logic [19:0] ew_pfn_even, ew_pfn_odd;
  logic        ew_val_even, ew_drt_even, ew_val_odd, ew_drt_odd;
  logic        rs_vld, rs_rd_ok, rs_wr_ok;
  logic [1:0]  rs_code;
  logic [31:0] rs_pa;

  always #10 clk = ~clk;

  ptlb_xlate uut (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_va(lk_va), .lk_wr(lk_wr),
    .cur_asid(cur_asid), .ew_en(ew_en), .ew_idx(ew_idx), .ew_tag(ew_tag),
    .ew_asid(ew_asid), .ew_glob(ew_glob), .ew_pfn_even(ew_pfn_even),
    .ew_val_even(ew_val_even), .ew_drt_even(ew_drt_even),
    .ew_pfn_odd(ew_pfn_odd), .ew_val_odd(ew_val_odd), .ew_drt_odd(ew_drt_odd),
    .rs_vld(rs_vld), .rs_code(rs_code), .rs_pa(rs_pa),
    .rs_rd_ok(rs_rd_ok), .rs_wr_ok(rs_wr_ok)
  );

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  // table model of the slots
  logic [18:0] m_tag  [16];
  logic [7:0]  m_asid [16];
  logic        m_g    [16];
  logic [19:0] m_pfn0 [16];
  logic        m_v0   [16];
  logic        m_d0   [16];
  logic [19:0] m_pfn1 [16];
  logic        m_v1   [16];
  logic        m_d1   [16];

  logic [35:0] exp_q[$];
  string       tag_q[$];

  task automatic chk(input logic ok, input string req, input logic [35:0] act,
                     input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] model(input logic [31:0] va, input logic wr,
                                        input logic [7:0] asid);
    int   hit = -1;
    logic v, d;
    logic [19:0] pfn;
    for (int i = 15; i >= 0; i--)
      if ((m_g[i] || m_asid[i] == asid) && m_tag[i] == va[31:13]) hit = i;
    if (hit < 0) return {2'b11, 32'h0, 1'b0, 1'b0};
    v   = va[12] ? m_v1[hit]   : m_v0[hit];
    d   = va[12] ? m_d1[hit]   : m_d0[hit];
    pfn = va[12] ? m_pfn1[hit] : m_pfn0[hit];
    if (!v) return {2'b01, 32'h0, 1'b0, 1'b0};
    if (wr && !d) return {2'b10, 32'h0, 1'b0, 1'b0};
    return {2'b00, pfn, va[11:0], 1'b1, d};
  endfunction

  task automatic drive_put(input int idx, input logic [18:0] tg, input logic [7:0] as,
                           input logic g, input logic [19:0] p0, input logic v0,
                           input logic d0, input logic [19:0] p1, input logic v1,
                           input logic d1);
    ew_en = 1'b1; ew_idx = 4'(idx); ew_tag = tg; ew_asid = as; ew_glob = g;
    ew_pfn_even = p0; ew_val_even = v0; ew_drt_even = d0;
    ew_pfn_odd = p1; ew_val_odd = v1; ew_drt_odd = d1;
    m_tag[idx] = tg; m_asid[idx] = as; m_g[idx] = g;
    m_pfn0[idx] = p0; m_v0[idx] = v0; m_d0[idx] = d0;
    m_pfn1[idx] = p1; m_v1[idx] = v1; m_d1[idx] = d1;
  endtask

  task automatic put(input int idx, input logic [18:0] tg, input logic [7:0] as,
                     input logic g, input logic [19:0] p0, input logic v0,
                     input logic d0, input logic [19:0] p1, input logic v1,
                     input logic d1);
    @(negedge clk);
    drive_put(idx, tg, as, g, p0, v0, d0, p1, v1, d1);
    @(posedge clk); #1 ew_en = 1'b0;
  endtask

  task automatic drive_look(input logic [31:0] va, input logic wr, input logic [7:0] as,
                            input string req);
    lk_req = 1'b1; lk_va = va; lk_wr = wr; cur_asid = as;
    exp_q.push_back(model(va, wr, as));
    tag_q.push_back(req);
  endtask

  task automatic look(input logic [31:0] va, input logic wr, input logic [7:0] as,
                      input string req);
    @(negedge clk);
    drive_look(va, wr, as, req);
    @(posedge clk); #1 lk_req = 1'b0;
  endtask

  // R12: lookup and slot write in one cycle, lookup judged on old contents
  task automatic look_and_put(input logic [31:0] va, input int idx,
                              input logic [18:0] tg, input logic [7:0] as);
    @(negedge clk);
    drive_look(va, 1'b0, as, "R12");
    drive_put(idx, tg, as, 1'b0, 20'hAAAAA, 1'b1, 1'b1, 20'hBBBBB, 1'b1, 1'b1);
    @(posedge clk); #1 begin lk_req = 1'b0; ew_en = 1'b0; end
  endtask

  // monitor: pops expectations as results appear
  always @(negedge clk) begin
    if (rst_n && rs_vld) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9", {rs_code, rs_pa, rs_rd_ok, rs_wr_ok}, 36'h0);
      end else begin
        logic [35:0] e;
        string r;
        e = exp_q.pop_front();
        r = tag_q.pop_front();
        chk({rs_code, rs_pa, rs_rd_ok, rs_wr_ok} == e, r,
            {rs_code, rs_pa, rs_rd_ok, rs_wr_ok}, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [1:0]  h_code;
    logic [31:0] h_pa;
    rst_n = 1'b0; lk_req = 1'b0; lk_va = '0; lk_wr = 1'b0; cur_asid = '0;
    ew_en = 1'b0; ew_idx = '0; ew_tag = '0; ew_asid = '0; ew_glob = 1'b0;
    ew_pfn_even = '0; ew_val_even = 1'b0; ew_drt_even = 1'b0;
    ew_pfn_odd = '0; ew_val_odd = 1'b0; ew_drt_odd = 1'b0;
    for (int i = 0; i < 16; i++) begin
      m_tag[i] = '0; m_asid[i] = '0; m_g[i] = 1'b0;
      m_pfn0[i] = '0; m_v0[i] = 1'b0; m_d0[i] = 1'b0;
      m_pfn1[i] = '0; m_v1[i] = 1'b0; m_d1[i] = 1'b0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    chk(!rs_vld && !rs_rd_ok && !rs_wr_ok && rs_pa == 32'h0, "R11",
        {rs_code, rs_pa, rs_rd_ok, rs_wr_ok}, {2'b11, 34'h0});
    look(32'h0000_0123, 1'b0, 8'h00, "R11");
    look(32'h0000_1123, 1'b1, 8'h00, "R11");
    look(32'h0000_0123, 1'b0, 8'h01, "R11");
    look(32'h1234_5678, 1'b0, 8'h00, "R11");

    // slot 3: even valid dirty, odd valid clean
    put(3, 19'h2A5C3, 8'h05, 1'b0, 20'h12345, 1'b1, 1'b1, 20'h54321, 1'b1, 1'b0);
    look({19'h2A5C3, 1'b0, 12'hABC}, 1'b0, 8'h05, "R7");
    look({19'h2A5C3, 1'b0, 12'h001}, 1'b1, 8'h05, "R7");
    look({19'h2A5C3, 1'b1, 12'hFFF}, 1'b0, 8'h05, "R4");
    look({19'h2A5C3, 1'b1, 12'h010}, 1'b1, 8'h05, "R6");
    look({19'h2A5C3, 1'b0, 12'h010}, 1'b0, 8'h06, "R2");
    look({19'h2A5C2, 1'b0, 12'h010}, 1'b0, 8'h05, "R3");
    look({19'h2A5C3 ^ 19'h40000, 1'b0, 12'h010}, 1'b0, 8'h05, "R8");

    // slot 7: global, even invalid, odd valid dirty
    put(7, 19'h01F00, 8'h09, 1'b1, 20'h0F0F0, 1'b0, 1'b1, 20'h77777, 1'b1, 1'b1);
    look({19'h01F00, 1'b0, 12'h222}, 1'b0, 8'h01, "R5");
    look({19'h01F00, 1'b0, 12'h222}, 1'b1, 8'h01, "R5");
    look({19'h01F00, 1'b1, 12'h333}, 1'b1, 8'h42, "R2");

    // R10: two slots with one tag
    put(10, 19'h33333, 8'h04, 1'b0, 20'hAAAA1, 1'b1, 1'b1, 20'hAAAA2, 1'b1, 1'b1);
    put(2,  19'h33333, 8'h04, 1'b0, 20'hBBBB1, 1'b1, 1'b0, 20'hBBBB2, 1'b1, 1'b0);
    look({19'h33333, 1'b0, 12'h444}, 1'b0, 8'h04, "R10");
    look({19'h33333, 1'b1, 12'h444}, 1'b1, 8'h04, "R10");
    put(2, 19'h00001, 8'h04, 1'b0, 20'h0, 1'b0, 1'b0, 20'h0, 1'b0, 1'b0);
    look({19'h33333, 1'b0, 12'h444}, 1'b1, 8'h04, "R10");

    // R12: write and lookup in one cycle, then lookup again
    look_and_put({19'h55555, 1'b0, 12'h0AB}, 12, 19'h55555, 8'h07);
    look({19'h55555, 1'b0, 12'h0AB}, 1'b1, 8'h07, "R12");

    // R9: idle hold
    @(negedge clk);
    h_code = rs_code; h_pa = rs_pa;
    repeat (3) @(negedge clk);
    chk(!rs_vld && rs_code == h_code && rs_pa == h_pa, "R9",
        {rs_code, rs_pa, rs_vld, 1'b0}, {h_code, h_pa, 2'b00});

    // R1: fill every slot, then look each one up back to back
    for (int i = 0; i < 16; i++)
      put(i, 19'h40000 + 19'(i), 8'h20, 1'b0, 20'h00100 + 20'(i), 1'b1, 1'b1,
          20'h00200 + 20'(i), 1'b1, 1'b0);
    for (int i = 0; i < 16; i++)
      look({19'h40000 + 19'(i), i[0], 12'h5A0 + 12'(i)}, 1'b0, 8'h20, "R1");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R9", 36'(exp_q.size()), 36'h0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule